// File: doc/BRIEF.md
# Soft-Decision Symbol Alignment and Depuncturing Front End

This block sits between a demodulator and a rate-1/2 Viterbi core. It takes 3-bit soft-decision code symbols and delivers them as G1/G2 pairs, one pair per trellis step. Each symbol of a pair carries an erasure flag, and an erased symbol is delivered with the value 000 so that the metric stage adds nothing for it.

Symbols enter either two per beat on separate ports (parallel mode) or one per beat on the G1 port (sequential mode). At rate 1/2 a sequential symbol is steered to G1 or G2 by a load-G2 pin, and per-symbol puncture flags supplied with the data mark erasures. At the internally supported punctured rates, a fixed keep pattern decides which pair positions receive the next incoming symbols. The positions that were deleted at the transmitter are put back as erasures.

Both data edges are valid/ready streams. An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` depends only on the internal symbol store, never on `in_valid`. An output pair is taken on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, a presented pair is held unchanged. When the output stalls, the internal store fills and `in_ready` drops. `rate_sel` and `parl` are static configuration, and they may change only while `rst` is high.

Top module: `sad_depuncture_top`

## Requirements
- R1: `rate_sel` 001 selects rate 2/3 with a period of 2 positions, 100 selects rate 3/4 with a period of 3, and 010 selects rate 7/8 with a period of 7. Every other code, including 000, selects rate 1/2 or external puncturing. The keep patterns are written with position 0 as the leftmost digit and 0 meaning deleted: rate 2/3 is G1 10 and G2 11; rate 3/4 is G1 101 and G2 110; rate 7/8 is G1 1000101 and G2 1111010.
- R2: At a punctured rate, received symbols fill the kept slots in arrival order, with G1 before G2 within a position. Exactly one pair is produced per pattern position. A deleted slot is output with erasure flag 1 and value 000. The position wraps to 0 after the last position of the period.
- R3: In parallel mode a beat carries two symbols, `in_g1` first and `in_g2` second in stream order. At rate 1/2 each parallel beat forms one pair: `in_g1` is G1 and `in_g2` is G2.
- R4: In sequential mode at rate 1/2, the symbol on `in_g1` is taken as G2 when `in_ldg2` is 1 and as G1 when it is 0. A G1 followed by a G2 forms one pair. A G2 with no pending G1 forms a pair whose G1 is erased. A G1 followed by another G1 is discarded.
- R5: At rate 1/2, a symbol whose puncture flag is 1 is output with erasure flag 1 and value 000, whatever value is on the pins. In parallel mode `in_punc1` marks the G1 symbol and `in_punc2` marks the G2 symbol. In sequential mode `in_punc2` applies when `in_ldg2` is 1, and `in_punc1` applies otherwise.
- R6: At a punctured rate the puncture flags have no effect. The erasure flags of a pair come from the pattern only.
- R7: `out_valid` is asserted once for each completed pair, including pairs that contain erasures. At a punctured rate, no pair has both symbols erased.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and the pair data stays unchanged. An input beat is consumed only on a cycle where `in_ready` is high.
- R9: A synchronous active-high `rst` discards all held symbols and pairs. In the cycle after reset, `out_valid` is 0 and `in_ready` is 1. The pattern position restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 3 | Rate code, static outside reset |
| parl | input | 1 | 1 = two symbols per beat, 0 = one symbol per beat |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be taken |
| in_g1 | input | 3 | First (or only) soft symbol of the beat |
| in_g2 | input | 3 | Second soft symbol of the beat, parallel mode only |
| in_ldg2 | input | 1 | Sequential rate-1/2 steering: 1 = symbol is G2 |
| in_punc1 | input | 1 | External erasure flag for G1 |
| in_punc2 | input | 1 | External erasure flag for G2 |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Output pair can be taken |
| out_g1 | output | 3 | G1 soft symbol, 000 when erased |
| out_g2 | output | 3 | G2 soft symbol, 000 when erased |
| out_era1 | output | 1 | G1 erasure flag |
| out_era2 | output | 1 | G2 erasure flag |

## Verification
The hardest case to reach is a parallel beat at rate 7/8 whose two symbols land in different pattern positions, or straddle the wrap from position 6 to 0, while the output is stalled and the store is full. The stimulus runs every rate in both input modes with heavily throttled `out_ready`, so that beats arrive at every pattern phase and under full back-pressure. A reset is also applied in the middle of a 7/8 stream to show that the position restarts at 0. Sequential rate-1/2 runs use a random load-G2 sequence, which produces the orphan-G2 and repeated-G1 cases in quantity.

// File: rtl/sad_pkg.sv
package sad_pkg;

  localparam int SYM_W = 3;
  localparam int POS_W = 3;
  localparam int PAT_W = 7;

  typedef enum logic [1:0] {
    MODE_HALF,
    MODE_R23,
    MODE_R34,
    MODE_R78
  } mode_e;

  typedef struct packed {
    logic [SYM_W-1:0] val;
    logic             era;
    logic             is_g2;
  } sym_t;

  function automatic mode_e decode_rate(input logic [2:0] code);
    case (code)
      3'b001:  return MODE_R23;
      3'b100:  return MODE_R34;
      3'b010:  return MODE_R78;
      default: return MODE_HALF;
    endcase
  endfunction

  function automatic logic [POS_W-1:0] period_of(input mode_e m);
    case (m)
      MODE_R23: return POS_W'(2);
      MODE_R34: return POS_W'(3);
      MODE_R78: return POS_W'(7);
      default:  return POS_W'(1);
    endcase
  endfunction

  // Keep masks, left aligned: position 0 is the MSB.
  function automatic logic [PAT_W-1:0] keep_mask(input mode_e m, input logic second);
    case (m)
      MODE_R23: return second ? 7'b1100000 : 7'b1000000;
      MODE_R34: return second ? 7'b1100000 : 7'b1010000;
      MODE_R78: return second ? 7'b1111010 : 7'b1000101;
      default:  return 7'b1000000;
    endcase
  endfunction

  function automatic logic keep_at(input mode_e m, input logic [POS_W-1:0] pos,
                                   input logic second);
    logic [PAT_W-1:0] sh;
    sh = keep_mask(m, second) << pos;
    return sh[PAT_W-1];
  endfunction

endpackage

// File: rtl/sad_sym_fifo.sv
module sad_sym_fifo
  import sad_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   push_n,
  input  sym_t                         push0,
  input  sym_t                         push1,
  input  logic [1:0]                   pop_n,
  output sym_t                         head0,
  output sym_t                         head1,
  output logic [$clog2(DEPTH+1)-1:0]   count
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  sym_t             mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      for (int l = 0; l < 2; l++) begin
        if (int'(push_n) > l)
          mem[wr_ptr + PTR_W'(l)] <= (l == 0) ? push0 : push1;
      end
      wr_ptr <= wr_ptr + PTR_W'(push_n);
      rd_ptr <= rd_ptr + PTR_W'(pop_n);
      count  <= count + CNT_W'(push_n) - CNT_W'(pop_n);
    end
  end

  assign head0 = mem[rd_ptr];
  assign head1 = mem[rd_ptr + PTR_W'(1)];

  // R8
  fifo_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(count) + int'(push_n)) <= (DEPTH + int'(pop_n)));

  // R8
  fifo_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    int'(pop_n) <= int'(count));

endmodule

// File: rtl/sad_pattern_seq.sv
module sad_pattern_seq
  import sad_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_e mode,
  input  logic  step,
  output logic  keep1,
  output logic  keep2
);

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] last;

  assign last = period_of(mode) - POS_W'(1);

  always_ff @(posedge clk) begin
    if (rst)
      pos <= '0;
    else if (step)
      pos <= (pos == last) ? '0 : pos + POS_W'(1);
  end

  assign keep1 = keep_at(mode, pos, 1'b0);
  assign keep2 = keep_at(mode, pos, 1'b1);

  // R2
  pos_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    pos < period_of(mode));

  // R7
  pos_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    keep1 || keep2);

endmodule

// File: rtl/sad_pair_builder.sv
module sad_pair_builder
  import sad_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  mode_e                       mode,
  input  logic                        parl,
  input  sym_t                        head0,
  input  sym_t                        head1,
  input  logic [$clog2(DEPTH+1)-1:0]  count,
  input  logic                        keep1,
  input  logic                        keep2,
  output logic [1:0]                  pop_n,
  output logic                        step,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [SYM_W-1:0]            out_g1,
  output logic [SYM_W-1:0]            out_g2,
  output logic                        out_era1,
  output logic                        out_era2
);

  localparam int CNT_W = $clog2(DEPTH+1);
  localparam sym_t ERASED = '{val: '0, era: 1'b1, is_g2: 1'b0};

  logic       can_load;
  logic       fire;
  logic       tag_path;
  logic [1:0] need;
  sym_t       s1;
  sym_t       s2;

  assign can_load = !out_valid || out_ready;
  assign tag_path = (mode == MODE_HALF) && !parl;
  assign need     = {1'b0, keep1} + {1'b0, keep2};

  always_comb begin
    fire  = 1'b0;
    pop_n = 2'd0;
    step  = 1'b0;
    s1    = ERASED;
    s2    = ERASED;
    if (tag_path) begin
      if (count >= CNT_W'(1) && head0.is_g2) begin
        if (can_load) begin
          fire  = 1'b1;
          pop_n = 2'd1;
          s2    = head0;
        end
      end else if (count >= CNT_W'(2)) begin
        if (head1.is_g2) begin
          if (can_load) begin
            fire  = 1'b1;
            pop_n = 2'd2;
            s1    = head0;
            s2    = head1;
          end
        end else begin
          pop_n = 2'd1;
        end
      end
    end else begin
      if (can_load && count >= CNT_W'(need)) begin
        fire  = 1'b1;
        step  = 1'b1;
        pop_n = need;
        if (keep1) s1 = head0;
        if (keep2) s2 = keep1 ? head1 : head0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_g1    <= '0;
      out_g2    <= '0;
      out_era1  <= 1'b0;
      out_era2  <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_g1    <= s1.era ? '0 : s1.val;
      out_g2    <= s2.era ? '0 : s2.val;
      out_era1  <= s1.era;
      out_era2  <= s2.era;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_g1) && $stable(out_g2)
                                && $stable(out_era1) && $stable(out_era2));

  // R5
  era1_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_era1 |-> out_g1 == '0);

  // R5
  era2_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_era2 |-> out_g2 == '0);

  // R7
  not_both_erased_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && mode != MODE_HALF |-> !(out_era1 && out_era2));

endmodule

// File: rtl/sad_depuncture_top.sv
module sad_depuncture_top
  import sad_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       rate_sel,
  input  logic             parl,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_g1,
  input  logic [SYM_W-1:0] in_g2,
  input  logic             in_ldg2,
  input  logic             in_punc1,
  input  logic             in_punc2,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SYM_W-1:0] out_g1,
  output logic [SYM_W-1:0] out_g2,
  output logic             out_era1,
  output logic             out_era2
);

  localparam int CNT_W = $clog2(DEPTH+1);

  mode_e            mode;
  logic             ext_ok;
  logic             accept;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] free;
  logic [1:0]       push_n;
  logic [1:0]       pop_n;
  sym_t             push0;
  sym_t             push1;
  sym_t             head0;
  sym_t             head1;
  logic             keep1;
  logic             keep2;
  logic             step;

  assign mode     = decode_rate(rate_sel);
  assign ext_ok   = (mode == MODE_HALF);
  assign free     = CNT_W'(DEPTH) - count;
  assign in_ready = parl ? (free >= CNT_W'(2)) : (free >= CNT_W'(1));
  assign accept   = in_valid && in_ready;
  assign push_n   = !accept ? 2'd0 : (parl ? 2'd2 : 2'd1);

  always_comb begin
    push0.val   = in_g1;
    push0.era   = (parl ? in_punc1 : (in_ldg2 ? in_punc2 : in_punc1)) && ext_ok;
    push0.is_g2 = parl ? 1'b0 : in_ldg2;
    push1.val   = in_g2;
    push1.era   = in_punc2 && ext_ok;
    push1.is_g2 = 1'b1;
  end

  sad_sym_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk    (clk),
    .rst    (rst),
    .push_n (push_n),
    .push0  (push0),
    .push1  (push1),
    .pop_n  (pop_n),
    .head0  (head0),
    .head1  (head1),
    .count  (count)
  );

  sad_pattern_seq pat_i (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .step  (step),
    .keep1 (keep1),
    .keep2 (keep2)
  );

  sad_pair_builder #(.DEPTH(DEPTH)) pair_i (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .parl      (parl),
    .head0     (head0),
    .head1     (head1),
    .count     (count),
    .keep1     (keep1),
    .keep2     (keep2),
    .pop_n     (pop_n),
    .step      (step),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_g1    (out_g1),
    .out_g2    (out_g2),
    .out_era1  (out_era1),
    .out_era2  (out_era2)
  );

  // R6
  ext_flag_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    accept && !ext_ok |-> !push0.era && !push1.era);

endmodule

// File: tb/sad_depuncture_top_tb_top.sv
module sad_depuncture_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rate_sel = 3'b000;
  logic       parl = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_g1 = '0;
  logic [2:0] in_g2 = '0;
  logic       in_ldg2 = 1'b0;
  logic       in_punc1 = 1'b0;
  logic       in_punc2 = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [2:0] out_g1;
  logic [2:0] out_g2;
  logic       out_era1;
  logic       out_era2;

  sad_depuncture_top dut_i (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .parl(parl),
    .in_valid(in_valid), .in_ready(in_ready), .in_g1(in_g1), .in_g2(in_g2),
    .in_ldg2(in_ldg2), .in_punc1(in_punc1), .in_punc2(in_punc2),
    .out_valid(out_valid), .out_ready(out_ready), .out_g1(out_g1), .out_g2(out_g2),
    .out_era1(out_era1), .out_era2(out_era2)
  );

  always #5 clk = ~clk;

  int       n_cmp = 0;
  int       n_bad = 0;
  bit       finished = 0;
  // model symbol: {val[2:0], flag, is_g2}
  bit [4:0] symq[$];
  bit [7:0] expq[$];
  int       mpos = 0;
  int       mcode = 0;
  bit       mparl = 1;
  bit       stall_prev = 0;
  bit [7:0] prev_word = '0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_internal();
    return (mcode == 1) || (mcode == 4) || (mcode == 2);
  endfunction

  function automatic int m_period();
    case (mcode)
      1: return 2;
      4: return 3;
      2: return 7;
      default: return 1;
    endcase
  endfunction

  function automatic bit m_keep(input int pos, input bit second);
    string p;
    case (mcode)
      1: p = second ? "11" : "10";
      4: p = second ? "110" : "101";
      2: p = second ? "1111010" : "1000101";
      default: p = "1";
    endcase
    return p.getc(pos) == "1";
  endfunction

  function automatic bit [3:0] m_half(input bit [4:0] s);
    return s[1] ? 4'b1000 : {1'b0, s[4:2]};
  endfunction

  function automatic bit [7:0] m_pair(input bit [4:0] a, input bit [4:0] b);
    return {m_half(a), m_half(b)};
  endfunction

  task automatic m_run();
    bit go = 1;
    bit [4:0] er = 5'b00010;
    while (go) begin
      go = 0;
      if (m_internal() || mparl) begin
        bit k1 = m_keep(mpos, 0);
        bit k2 = m_keep(mpos, 1);
        int need = int'(k1) + int'(k2);
        if (symq.size() >= need) begin
          bit [4:0] a = k1 ? symq[0] : er;
          bit [4:0] b = k2 ? symq[k1 ? 1 : 0] : er;
          expq.push_back(m_pair(a, b));
          for (int i = 0; i < need; i++) void'(symq.pop_front());
          mpos = (mpos + 1) % m_period();
          go = 1;
        end
      end else begin
        if (symq.size() >= 1 && symq[0][0]) begin
          expq.push_back(m_pair(er, symq[0]));
          void'(symq.pop_front());
          go = 1;
        end else if (symq.size() >= 2) begin
          if (symq[1][0]) begin
            expq.push_back(m_pair(symq[0], symq[1]));
            void'(symq.pop_front());
            void'(symq.pop_front());
          end else begin
            void'(symq.pop_front());
          end
          go = 1;
        end
      end
    end
  endtask

  task automatic cyc(input string req, input int vprob, input int rprob, input bit frand);
    bit [7:0] word;
    @(negedge clk);
    in_valid  = ($urandom_range(0, 99) < vprob);
    in_g1     = 3'($urandom_range(0, 7));
    in_g2     = 3'($urandom_range(0, 7));
    in_ldg2   = 1'($urandom_range(0, 1));
    in_punc1  = frand ? ($urandom_range(0, 3) == 0) : 1'b0;
    in_punc2  = frand ? ($urandom_range(0, 3) == 0) : 1'b0;
    out_ready = ($urandom_range(0, 99) < rprob);
    #1;
    word = {out_era1, out_g1, out_era2, out_g2};
    if (stall_prev) begin
      chk("R8 hold valid", int'(out_valid), 1);
      chk("R8 hold data", int'(word), int'(prev_word));
    end
    chk({req, " R7 no spurious pair"}, int'(out_valid && expq.size() == 0), 0);
    if (out_valid && out_ready && expq.size() != 0)
      chk({req, " pair"}, int'(word), int'(expq.pop_front()));
    stall_prev = out_valid && !out_ready;
    prev_word  = word;
    if (in_valid && in_ready) begin
      bit ok = !m_internal();
      if (parl) begin
        symq.push_back({in_g1, in_punc1 & ok, 1'b0});
        symq.push_back({in_g2, in_punc2 & ok, 1'b1});
      end else begin
        symq.push_back({in_g1, (in_ldg2 ? in_punc2 : in_punc1) & ok, in_ldg2});
      end
      m_run();
    end
  endtask

  task automatic do_reset(input int code, input bit p);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    out_ready = 1'b0;
    rate_sel = 3'(code);
    parl = p;
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R9
    chk("R9 reset out_valid", int'(out_valid), 0);
    chk("R9 reset in_ready", int'(in_ready), 1);
    symq.delete();
    expq.delete();
    mpos = 0;
    mcode = code;
    mparl = p;
    stall_prev = 0;
  endtask

  task automatic drain(input string req);
    repeat (20) cyc(req, 0, 100, 0);
    chk({req, " R7 all pairs delivered"}, expq.size(), 0);
  endtask

  task automatic phase(input string req, input int code, input bit p, input int n,
                       input int vprob, input int rprob);
    do_reset(code, p);
    repeat (n) cyc(req, vprob, rprob, 1);
    drain(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R3 R5: rate 1/2 parallel with external flags
    phase("R3/R5", 0, 1, 300, 70, 60);
    // R4 R5: rate 1/2 sequential with random steering
    phase("R4/R5", 0, 0, 400, 70, 60);
    // R1 R2 R6: punctured rates, both input modes
    phase("R1/R2/R6 rate23 par", 1, 1, 300, 70, 60);
    phase("R1/R2/R6 rate23 seq", 1, 0, 300, 70, 60);
    phase("R1/R2/R6 rate34 par", 4, 1, 300, 70, 60);
    phase("R1/R2/R6 rate34 seq", 4, 0, 300, 70, 60);
    phase("R1/R2/R6 rate78 par", 2, 1, 300, 70, 60);
    phase("R1/R2/R6 rate78 seq", 2, 0, 300, 70, 60);
    // R1: unassigned code behaves as rate 1/2
    phase("R1 code011", 3, 1, 200, 70, 60);
    // R8: heavy back-pressure at rate 7/8
    phase("R8 rate78 stall", 2, 1, 400, 90, 20);
    phase("R8 rate34 seq stall", 4, 0, 300, 90, 20);
    // R9: reset in the middle of a rate 7/8 stream
    do_reset(2, 1);
    repeat (37) cyc("R9 pre", 80, 50, 1);
    do_reset(2, 1);
    repeat (200) cyc("R9 post", 80, 50, 1);
    drain("R9 post");
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule